// File: doc/BRIEF.md
# DMA Software Request Register Bank

This block holds three small request registers through which software can ask the DMA channel engine to service a peripheral source. The three request kinds are single transfer, final burst and final single transfer. Each kind has its own register with one bit per source. Writing a one to a bit raises a pending request, and writing a zero leaves that bit alone. A pending bit stays set until the engine pulses the completion acknowledge for that source and kind, and the block then clears it.

Each pending software bit is ORed with the matching hardware request line from the peripheral, and the result drives the engine. Software uses a simple register port with a write strobe, a byte address and 32-bit data, and reads combinationally. Source bits 0 to 4 stand for SSP0 transmit, SSP0 receive, SSP1 transmit, SSP1 receive and SD/MMC. In the final-burst register only the SD/MMC bit exists.

Top module: `dma_swreq_bank`

## Requirements
- R1: After rst_ni is asserted, all three registers read 0, and every merged request output is 0 while the hardware request lines are 0.
- R2: A write with we_i=1 sets every data bit that is 1 and implemented in the addressed register, from the next clock edge on. Bit i is source i: 0=SSP0 tx, 1=SSP0 rx, 2=SSP1 tx, 3=SSP1 rx, 4=SD/MMC.
- R3: Writing 0 to a bit does not change the stored value of that bit.
- R4: A one-cycle completion pulse on a source bit of a request kind clears that stored bit at the next edge.
- R5: If a write of 1 and a completion pulse hit the same bit in the same cycle, the bit is set after the edge.
- R6: Reading byte offset 0x24 returns the single register, 0x28 the final-burst register and 0x2C the final-single register. The pending bits appear at the source bit positions.
- R7: In the final-burst register only bit 4 is implemented. Its bits 3:0, and bits 31:5 of every register, ignore writes and read 0.
- R8: Each request output bit equals the hardware line OR the stored software bit, for the same source and kind.
- R9: A write to any other address changes no register, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data, one means set |
| rdata_o | output | 32 | Combinational read data for addr_i |
| hw_sreq_i | input | 5 | Peripheral single-request lines |
| hw_lbreq_i | input | 5 | Peripheral final-burst request lines |
| hw_lsreq_i | input | 5 | Peripheral final-single request lines |
| done_sreq_i | input | 5 | Engine completion pulses, single kind |
| done_lbreq_i | input | 5 | Engine completion pulses, final-burst kind |
| done_lsreq_i | input | 5 | Engine completion pulses, final-single kind |
| dma_sreq_o | output | 5 | Merged single requests to the engine |
| dma_lbreq_o | output | 5 | Merged final-burst requests |
| dma_lsreq_o | output | 5 | Merged final-single requests |

## Verification
A software set and a completion clear can land on the same bit in the same cycle, and the set has to win. The bench forces this case with directed writes whose data overlaps a completion pulse of the same kind and source. It also mixes random write data with random completion vectors, so overlaps and near-overlaps happen often. After each edge a reference model applies set-over-clear, and the bench compares the model with both the readback and the merged outputs.

// File: rtl/dma_swreq_pkg.sv
package dma_swreq_pkg;
  localparam int unsigned NUM_SRC   = 5;
  localparam int unsigned NUM_KIND  = 3;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SDMMC_BIT = 4;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_LBURST = 2'd1,
    KIND_LSINGLE = 2'd2
  } req_kind_e;

  // word offsets are fixed by software
  localparam logic [ADDR_W-1:0] OFS_SINGLE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_LBURST  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LSINGLE = 8'h2C;

  function automatic logic [NUM_SRC-1:0] kind_mask(input int unsigned k);
    logic [NUM_SRC-1:0] m;
    if (k == int'(KIND_LBURST)) begin
      m = '0;
      m[SDMMC_BIT] = 1'b1;
    end else begin
      m = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_swreq_decode.sv
module dma_swreq_decode
  import dma_swreq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0]       addr_i,
  output logic [NUM_KIND-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (addr_i)
      OFS_SINGLE:  sel_o[KIND_SINGLE]  = 1'b1;
      OFS_LBURST:  sel_o[KIND_LBURST]  = 1'b1;
      OFS_LSINGLE: sel_o[KIND_LSINGLE] = 1'b1;
      default:     sel_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_swreq_reg.sv
module dma_swreq_reg
  import dma_swreq_pkg::*;
#(
  parameter int unsigned        N    = NUM_SRC,
  parameter logic [N-1:0]       MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] done_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] set_v;
  logic [N-1:0] q_d;

  assign set_v = we_i ? (wdata_i & MASK) : '0;
  // set takes priority over completion
  assign q_d   = (q_o & ~done_i) | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  assert_w1s_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & $past(wdata_i & MASK)) == $past(wdata_i & MASK)));

  assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((q_o & ~$past(q_o)) == '0));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((q_o & $past(done_i)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ((wdata_i & done_i & MASK) != '0)) |=>
      ((q_o & $past(wdata_i & done_i & MASK)) == $past(wdata_i & done_i & MASK)));

  assert_rsvd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~MASK) == '0);
endmodule

// File: rtl/dma_swreq_merge.sv
module dma_swreq_merge
  import dma_swreq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_i,
  input  logic [N-1:0] sw_i,
  output logic [N-1:0] req_o
);
  assign req_o = hw_i | sw_i;

  assert_merge_hw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_i & ~req_o) == '0);
  assert_merge_sw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_i & ~req_o) == '0);
endmodule

// File: rtl/dma_swreq_bank.sv
module dma_swreq_bank
  import dma_swreq_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  hw_sreq_i,
  input  logic [N-1:0]  hw_lbreq_i,
  input  logic [N-1:0]  hw_lsreq_i,
  input  logic [N-1:0]  done_sreq_i,
  input  logic [N-1:0]  done_lbreq_i,
  input  logic [N-1:0]  done_lsreq_i,
  output logic [N-1:0]  dma_sreq_o,
  output logic [N-1:0]  dma_lbreq_o,
  output logic [N-1:0]  dma_lsreq_o
);
  localparam int unsigned PAD_W = DW - N;

  logic [NUM_KIND-1:0]         sel;
  logic [NUM_KIND-1:0][N-1:0]  done_v;
  logic [NUM_KIND-1:0][N-1:0]  hw_v;
  logic [NUM_KIND-1:0][N-1:0]  sw_q;
  logic [NUM_KIND-1:0][N-1:0]  req_v;
  logic                        unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DW-1:N];

  assign done_v[KIND_SINGLE]  = done_sreq_i;
  assign done_v[KIND_LBURST]  = done_lbreq_i;
  assign done_v[KIND_LSINGLE] = done_lsreq_i;
  assign hw_v[KIND_SINGLE]    = hw_sreq_i;
  assign hw_v[KIND_LBURST]    = hw_lbreq_i;
  assign hw_v[KIND_LSINGLE]   = hw_lsreq_i;

  dma_swreq_decode #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    dma_swreq_reg #(.N(N), .MASK(kind_mask(k))) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i & sel[k]),
      .wdata_i (wdata_i[N-1:0]),
      .done_i  (done_v[k]),
      .q_o     (sw_q[k])
    );
    dma_swreq_merge #(.N(N)) u_merge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hw_i   (hw_v[k]),
      .sw_i   (sw_q[k]),
      .req_o  (req_v[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_KIND; k++) begin
      if (sel[k]) rdata_o = {{PAD_W{1'b0}}, sw_q[k]};
    end
  end

  assign dma_sreq_o  = req_v[KIND_SINGLE];
  assign dma_lbreq_o = req_v[KIND_LBURST];
  assign dma_lsreq_o = req_v[KIND_LSINGLE];

  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (sel == '0) && (done_v == '0)) |=> $stable(sw_q));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == '0) |-> (rdata_o == '0));

  assert_rsvd_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N] == '0);

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (sw_q == '0));
endmodule

// File: tb/tb_dma_swreq_bank.sv
module tb_dma_swreq_bank;
  localparam int N = 5;
  localparam logic [7:0] A_S = 8'h24, A_LB = 8'h28, A_LS = 8'h2C;
  localparam logic [N-1:0] LB_MASK = 5'b10000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we;
  logic [7:0] addr;
  logic [31:0] wdata, rdata;
  logic [N-1:0] hw_s, hw_lb, hw_ls, d_s, d_lb, d_ls;
  logic [N-1:0] o_s, o_lb, o_ls;
  logic [N-1:0] m_s, m_lb, m_ls;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_swreq_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hw_sreq_i(hw_s), .hw_lbreq_i(hw_lb), .hw_lsreq_i(hw_ls),
    .done_sreq_i(d_s), .done_lbreq_i(d_lb), .done_lsreq_i(d_ls),
    .dma_sreq_o(o_s), .dma_lbreq_o(o_lb), .dma_lsreq_o(o_ls)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_S:     return {27'd0, m_s};
      A_LB:    return {27'd0, m_lb};
      A_LS:    return {27'd0, m_ls};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    we = 1'b0; addr = 8'h00; wdata = '0;
    hw_s = '0; hw_lb = '0; hw_ls = '0; d_s = '0; d_lb = '0; d_ls = '0;
  endtask

  // apply inputs for one cycle, update model, then check read and outputs
  task automatic step(input string req);
    logic [N-1:0] ws;
    @(posedge clk);
    ws = wdata[N-1:0];
    m_s  = (m_s  & ~d_s)  | ((we && addr == A_S)  ? ws : '0);
    m_lb = (m_lb & ~d_lb) | ((we && addr == A_LB) ? (ws & LB_MASK) : '0);
    m_ls = (m_ls & ~d_ls) | ((we && addr == A_LS) ? ws : '0);
    #1;
    chk({req, " read"}, rdata, model_read(addr));
    chk("R8 single out", {27'd0, o_s},  {27'd0, hw_s | m_s});
    chk("R8 lburst out", {27'd0, o_lb}, {27'd0, hw_lb | m_lb});
    chk("R8 lsingle out", {27'd0, o_ls}, {27'd0, hw_ls | m_ls});
    @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    m_s = '0; m_lb = '0; m_ls = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 single", A_S, 0); rd("R1 lburst", A_LB, 0); rd("R1 lsingle", A_LS, 0);
    chk("R1 outputs", {17'd0, o_s, o_lb, o_ls}, 32'd0);

    // R2 set SSP0 tx and SD/MMC in single
    idle(); we = 1; addr = A_S; wdata = 32'h0000_0011; step("R2");
    idle(); rd("R2 single bits 0,4", A_S, 32'h11);
    // R3 write zeros: no change
    idle(); we = 1; addr = A_S; wdata = 32'h0; step("R3");
    idle(); rd("R3 single hold", A_S, 32'h11);
    // R7 lburst only bit 4, upper bits ignored everywhere
    idle(); we = 1; addr = A_LB; wdata = 32'hFFFF_FFEF; step("R7");
    idle(); rd("R7 lburst low bits", A_LB, 32'h0);
    idle(); we = 1; addr = A_LB; wdata = 32'hFFFF_FFFF; step("R7");
    idle(); rd("R7 lburst bit4", A_LB, 32'h10);
    idle(); we = 1; addr = A_LS; wdata = 32'hFFFF_FFE4; step("R7");
    idle(); rd("R6 lsingle SSP1 tx", A_LS, 32'h04);
    // R4 completion clears SD/MMC single
    idle(); d_s = 5'b10000; step("R4");
    idle(); rd("R4 single cleared", A_S, 32'h01);
    // R5 write and completion same bit same cycle
    idle(); we = 1; addr = A_LS; wdata = 32'h04; d_ls = 5'b00100; step("R5");
    idle(); rd("R5 set wins", A_LS, 32'h04);
    // R9 unmapped write/read
    idle(); we = 1; addr = 8'h30; wdata = 32'hFFFF_FFFF; step("R9");
    idle(); rd("R9 unmapped read", 8'h20, 32'h0);
    rd("R9 single intact", A_S, 32'h01);
    rd("R9 lburst intact", A_LB, 32'h10);
    // R8 hardware lines alone
    idle(); d_s = '1; d_lb = '1; d_ls = '1; step("R4");
    idle(); hw_lb = 5'b01010; #1;
    chk("R8 hw only", {27'd0, o_lb}, {27'd0, 5'b01010});

    // random mix, R6 readback and R8 merge
    for (int i = 0; i < 3000; i++) begin
      int sel;
      idle();
      we = ($urandom % 2) == 1;
      sel = $urandom % 4;
      addr = (sel == 0) ? A_S : (sel == 1) ? A_LB : (sel == 2) ? A_LS : 8'($urandom);
      wdata = $urandom;
      hw_s = 5'($urandom); hw_lb = 5'($urandom); hw_ls = 5'($urandom);
      d_s = 5'($urandom) & 5'($urandom);
      d_lb = 5'($urandom) & 5'($urandom);
      d_ls = 5'($urandom) & 5'($urandom);
      step("R6");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule